// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple clocked host port and an external asynchronous static RAM of 24-bit words, 17 address bits deep. The word is split into three byte lanes, and each lane has its own active-low chip enable, write enable and output enable. The host presents one request at a time: a strobe, a read/write flag, an address, write data and a three-bit lane mask. The controller turns that request into a timed strobe sequence on the memory pins. Every window of that sequence is a whole number of clock cycles and is set by a parameter.

A write runs through three phases. First comes an address-setup phase with data already driven. Then the write strobe is held low for the pulse phase. Last comes a hold phase, in which data stays driven after the strobe has risen. A read holds chip enable and output enable low for the access-time count and then captures the bus. One cycle later it returns the word with a single-cycle valid pulse. Lanes outside the mask take no part in either operation and read back as zero.

The memory data bus is modelled as separate output and input vectors plus one drive-enable, which a pad ring turns into the tristate pins.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, host_ready is 1, host_rvalid is 0, every mem_ce_n, mem_we_n and mem_oe_n bit is 1, and mem_dq_oe is 0.
- R2: A write with lane mask M holds mem_ce_n low on exactly the lanes in M for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles, starting in the cycle after acceptance. Within that window mem_we_n is low on the same lanes for exactly PULSE_CYC cycles, beginning after SETUP_CYC cycles. Lanes outside M keep all three strobes high. Mask bit i selects lane i, and lane i is data bits 8i+7..8i.
- R3: No lane ever has write enable and output enable low together. Output enable stays high for the whole of a write, and write enable stays high for the whole of a read.
- R4: mem_dq_oe is 1 only during the setup, pulse and hold phases of a write. It is still 1 in the cycle after the write strobe rises, and it drops when chip enable returns high.
- R5: A read with mask M holds mem_ce_n and mem_oe_n low on the lanes in M for ACCESS_CYC cycles. It then pulses host_rvalid for one cycle. host_rdata carries the bus value on the lanes in M and zero on the other lanes.
- R6: A write changes only the lanes in its mask. The other lanes of the addressed word keep their earlier contents.
- R7: host_ready is 0 from the cycle after acceptance until all strobes are high again. A request strobed while host_ready is 0 is ignored and causes no memory access.
- R8: A request with an all-zero mask touches no strobe and does not drop host_ready. A zero-mask read produces host_rvalid with all-zero data in the cycle after acceptance.
- R9: mem_addr equals the accepted address and holds steady for as long as host_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request strobe, taken when host_ready is 1 |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 24 | Write data |
| host_lanes | input | 3 | Lane mask, bit i selects data bits 8i+7..8i |
| host_ready | output | 1 | Controller idle and able to accept |
| host_rdata | output | 24 | Read data, unselected lanes zero |
| host_rvalid | output | 1 | One-cycle pulse with read data |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 3 | Per-lane chip enable, active low |
| mem_we_n | output | 3 | Per-lane write enable, active low |
| mem_oe_n | output | 3 | Per-lane output enable, active low |
| mem_dq_out | output | 24 | Data driven toward the memory |
| mem_dq_in | input | 24 | Data returned from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench tries writes and reads with full, single-lane, two-lane and empty lane masks. It follows each one cycle by cycle against the strobe pattern expected from the phase lengths, which separates lane selection errors from phase-length errors. Partial writes over earlier full writes, read back with narrower masks, separate lane merging from lane masking. The memory model drives a fixed non-zero pattern on lanes that are not reading, so a missing mask on capture shows up in the data. A strobe issued during a busy write, a zero-mask write and a zero-mask read check that ignored requests really leave the memory untouched. A sweep over many addresses, including the top one, with all eight masks, exercises the scoreboard under back-to-back traffic.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_WHOLD   = 3'd3,
    ST_RACCESS = 3'd4
  } phase_t;

  // longest phase decides the width of the shared down-counter
  function automatic int cyc_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int cnt_width(input int longest);
    return (longest < 2) ? 1 : $clog2(longest);
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_wr,
  output phase_t phase,
  output logic   capture
);
  localparam int LONGEST = cyc_max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, ACCESS_CYC);
  localparam int CNT_W   = cnt_width(LONGEST);

  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last    = (cnt == '0);
  assign capture = (phase == ST_RACCESS) && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        ST_IDLE: begin
          if (start) begin
            if (start_wr) begin
              phase <= ST_WSETUP;
              cnt   <= CNT_W'(SETUP_CYC - 1);
            end else begin
              phase <= ST_RACCESS;
              cnt   <= CNT_W'(ACCESS_CYC - 1);
            end
          end
        end
        ST_WSETUP: begin
          if (last) begin
            phase <= ST_WPULSE;
            cnt   <= CNT_W'(PULSE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WPULSE: begin
          if (last) begin
            phase <= ST_WHOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WHOLD, ST_RACCESS: begin
          if (last) phase <= ST_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe
  import sram_lane_pkg::*;
(
  input  phase_t phase,
  input  logic   sel,
  output logic   ce_n,
  output logic   we_n,
  output logic   oe_n
);
  assign ce_n = ~(sel && (phase != ST_IDLE));
  assign we_n = ~(sel && (phase == ST_WPULSE));
  assign oe_n = ~(sel && (phase == ST_RACCESS));
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              empty_read,
  input  logic [LANES-1:0]  lanes,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture || empty_read;
      if (capture)         rdata <= dq_in & lane_bits(lanes);
      else if (empty_read) rdata <= '0;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int LANES      = 3,
  parameter int LANE_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_lanes,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_ce_n,
  output logic [LANES-1:0]  mem_we_n,
  output logic [LANES-1:0]  mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  // named internal events, also seen by the bound checker
  phase_t            phase;
  logic              accept;
  logic              empty_req;
  logic              empty_read;
  logic              capture;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [LANES-1:0]  lat_lanes;

  assign host_ready = (phase == ST_IDLE);
  assign accept     = host_req && host_ready;
  assign empty_req  = (host_lanes == '0);
  assign empty_read = accept && empty_req && !host_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_lanes <= '0;
    end else if (accept && !empty_req) begin
      lat_addr  <= host_addr;
      lat_wdata <= host_wdata;
      lat_lanes <= host_lanes;
    end
  end

  sram_lane_seq #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .ACCESS_CYC(ACCESS_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept && !empty_req),
    .start_wr(host_wr),
    .phase   (phase),
    .capture (capture)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_strobe u_strobe (
      .phase(phase),
      .sel  (lat_lanes[g]),
      .ce_n (mem_ce_n[g]),
      .we_n (mem_we_n[g]),
      .oe_n (mem_oe_n[g])
    );
  end

  assign mem_addr   = lat_addr;
  assign mem_dq_out = lat_wdata;
  assign mem_dq_oe  = (phase == ST_WSETUP) || (phase == ST_WPULSE) || (phase == ST_WHOLD);

  sram_lane_capture #(
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .empty_read(empty_read),
    .lanes     (lat_lanes),
    .dq_in     (mem_dq_in),
    .rdata     (host_rdata),
    .rvalid    (host_rvalid)
  );
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int ADDR_W    = 17,
  parameter int LANES     = 3,
  parameter int PULSE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_ce_n,
  input logic [LANES-1:0]  mem_we_n,
  input logic [LANES-1:0]  mem_oe_n,
  input logic              mem_dq_oe,
  input logic              capture
);
  logic       we_any;
  logic [7:0] we_len;

  assign we_any = ~&mem_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n)      we_len <= '0;
    else if (we_any) we_len <= we_len + 1'b1;
    else             we_len <= '0;
  end

  a_r2_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_we_n & mem_ce_n) == '0));

  a_r2_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_any && $past(we_any)) |-> (we_len == 8'(PULSE_CYC)));

  a_r3_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_we_n & ~mem_oe_n) == '0));

  a_r4_drive_not_reading: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (&mem_oe_n));

  a_r4_drive_held_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    we_any |=> mem_dq_oe);

  a_r5_capture_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> host_rvalid);

  a_r7_busy_while_strobing: assert property (@(posedge clk) disable iff (!rst_n)
    (~&mem_ce_n) |-> !host_ready);

  a_r9_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && $past(!host_ready)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .ADDR_W   (ADDR_W),
  .LANES    (LANES),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .host_rvalid(host_rvalid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe),
  .capture    (capture)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;
  localparam int S = 1, P = 2, H = 1, A = 2;
  localparam int WLEN = S + P + H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [16:0] host_addr = '0;
  logic [23:0] host_wdata = '0;
  logic [2:0]  host_lanes = '0;
  logic        host_ready, host_rvalid, mem_dq_oe;
  logic [23:0] host_rdata, mem_dq_out;
  logic [23:0] mem_dq_in = '0;
  logic [16:0] mem_addr;
  logic [2:0]  mem_ce_n, mem_we_n, mem_oe_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [23:0] sb_q[$];
  logic [23:0] model_mem[bit [16:0]];
  logic [23:0] ref_mem[bit [16:0]];

  always #5 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_lanes(host_lanes),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // bench's own view of lane selection: lane i is bits 8i+7..8i
  function automatic logic [23:0] keep(input logic [23:0] w, input logic [2:0] m);
    return {m[2] ? w[23:16] : 8'h00, m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  function automatic logic [23:0] ref_word(input logic [16:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 24'h0;
  endfunction

  // memory model: writes land on selected lanes, reads return data, idle lanes float to C3
  always @(negedge clk) begin
    logic [23:0] w;
    w = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 24'h0;
    for (int i = 0; i < 3; i++)
      if (!mem_ce_n[i] && !mem_we_n[i] && mem_dq_oe) w[i*8 +: 8] = mem_dq_out[i*8 +: 8];
    model_mem[mem_addr] = w;
    for (int i = 0; i < 3; i++)
      mem_dq_in[i*8 +: 8] <= (!mem_ce_n[i] && !mem_oe_n[i] && mem_we_n[i]) ? w[i*8 +: 8] : 8'hC3;
  end

  // scoreboard monitor (R5, R6)
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (sb_q.size() == 0) chk(1'b0, "R5 unexpected rvalid", {8'h0, host_rdata}, 32'h0);
      else begin
        logic [23:0] e;
        e = sb_q.pop_front();
        chk(host_rdata == e, "R5/R6 read data", {8'h0, host_rdata}, {8'h0, e});
      end
    end
  end

  task automatic issue(input bit w, input logic [16:0] a, input logic [23:0] d, input logic [2:0] m);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    if (w) ref_mem[a] = keep(d, m) | keep(ref_word(a), ~m);
    else   sb_q.push_back(keep(ref_word(a), m));
    host_req = 1'b1; host_wr = w; host_addr = a; host_wdata = d; host_lanes = m;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  // cycle-by-cycle write trace (R2, R3, R4, R7, R9)
  task automatic write_trace(input logic [16:0] a, input logic [23:0] d, input logic [2:0] m);
    issue(1'b1, a, d, m);
    for (int k = 1; k <= WLEN + 1; k++) begin
      bit in_w, pulse;
      in_w  = (k <= WLEN);
      pulse = (k > S) && (k <= S + P);
      chk(mem_ce_n == (in_w ? ~m : 3'b111), "R2 ce_n in write", {29'h0, mem_ce_n}, {29'h0, in_w ? ~m : 3'b111});
      chk(mem_we_n == (pulse ? ~m : 3'b111), "R2 we_n in write", {29'h0, mem_we_n}, {29'h0, pulse ? ~m : 3'b111});
      chk(mem_oe_n == 3'b111, "R3 oe_n high in write", {29'h0, mem_oe_n}, 32'h7);
      chk(mem_dq_oe == in_w, "R4 drive window", {31'h0, mem_dq_oe}, {31'h0, in_w});
      chk(host_ready == !in_w, "R7 ready in write", {31'h0, host_ready}, {31'h0, !in_w});
      if (in_w) chk(mem_addr == a, "R9 address held", {15'h0, mem_addr}, {15'h0, a});
      if (k <= WLEN) @(negedge clk);
    end
  endtask

  // cycle-by-cycle read trace (R3, R5)
  task automatic read_trace(input logic [16:0] a, input logic [2:0] m);
    issue(1'b0, a, 24'h0, m);
    for (int k = 1; k <= A + 1; k++) begin
      bit in_r;
      in_r = (k <= A);
      chk(mem_ce_n == (in_r ? ~m : 3'b111), "R5 ce_n in read", {29'h0, mem_ce_n}, {29'h0, in_r ? ~m : 3'b111});
      chk(mem_oe_n == (in_r ? ~m : 3'b111), "R5 oe_n in read", {29'h0, mem_oe_n}, {29'h0, in_r ? ~m : 3'b111});
      chk(mem_we_n == 3'b111, "R3 we_n high in read", {29'h0, mem_we_n}, 32'h7);
      chk(mem_dq_oe == 1'b0, "R4 no drive in read", {31'h0, mem_dq_oe}, 32'h0);
      chk(host_rvalid == !in_r, "R5 rvalid timing", {31'h0, host_rvalid}, {31'h0, !in_r});
      if (k <= A) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(host_ready && !host_rvalid, "R1 ready/rvalid in reset", {30'h0, host_ready, host_rvalid}, 32'h2);
    chk({mem_ce_n, mem_we_n, mem_oe_n} == 9'h1FF, "R1 strobes in reset", {23'h0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h1FF);
    chk(!mem_dq_oe, "R1 drive in reset", {31'h0, mem_dq_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ready && {mem_ce_n, mem_we_n, mem_oe_n} == 9'h1FF && !mem_dq_oe, "R1 after reset",
        {22'h0, host_ready, mem_ce_n, mem_we_n, mem_oe_n}, 32'h3FF);

    write_trace(17'd5, 24'h123456, 3'b111);
    read_trace(17'd5, 3'b111);
    write_trace(17'd6, 24'hAABBCC, 3'b101);   // R6: lane 1 stays zero
    read_trace(17'd6, 3'b111);
    issue(1'b1, 17'd6, 24'h112233, 3'b010);   // R6: merge middle lane
    read_trace(17'd6, 3'b010);                // R5: other lanes masked to zero
    read_trace(17'd6, 3'b111);

    // R8: zero-mask write leaves memory and ready alone
    issue(1'b1, 17'd5, 24'h000000, 3'b000);
    chk(host_ready && mem_ce_n == 3'b111 && !mem_dq_oe, "R8 zero-mask write idle",
        {27'h0, host_ready, mem_ce_n, mem_dq_oe}, 32'h1E);
    read_trace(17'd5, 3'b111);
    // R8: zero-mask read returns zero next cycle
    issue(1'b0, 17'd5, 24'h0, 3'b000);
    chk(host_rvalid && host_ready && mem_ce_n == 3'b111, "R8 zero-mask read",
        {27'h0, host_rvalid, host_ready, mem_ce_n}, 32'h1F);

    // R7: a strobe while busy is ignored
    issue(1'b1, 17'd9, 24'h0F0F0F, 3'b111);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 17'd5; host_wdata = 24'hFFFFFF; host_lanes = 3'b111;
    @(negedge clk);
    host_req = 1'b0;
    read_trace(17'd5, 3'b111);
    read_trace(17'd9, 3'b111);

    // sweep of addresses and masks, including the top address
    for (int i = 0; i < 24; i++)
      issue(1'b1, (i == 23) ? 17'h1FFFF : 17'((i * 7919) & 17'h1FFFF),
            24'((i * 32'h10F0E1) ^ 32'h5A5A5A), 3'(i % 8));
    for (int i = 0; i < 24; i++)
      issue(1'b0, (i == 23) ? 17'h1FFFF : 17'((i * 7919) & 17'h1FFFF), 24'h0, 3'((i + 3) % 8));

    repeat (10) @(negedge clk);
    chk(sb_q.size() == 0, "R5 all reads answered", sb_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule